// File: doc/BRIEF.md
# Configuration Handshake Sequencer

This block brings a target programmable device through its configuration sequence and feeds it the payload. On a start request it pulls the device's active-low program line, waits for the device to acknowledge by pulling its init line low, releases program, and waits for init to come back high. It then accepts the requested number of payload bytes on a valid/ready stream and writes each one to a parallel data port with a one-cycle write strobe. Each byte can optionally be bit-reversed on the way.

While bytes are being written, the init line is watched for a configuration error. After the last byte, the block waits for the done line. Each wait is a bounded poll of one sample per clock. Init and done pass through a two-stage synchroniser before they are used. The outcome is reported as one of four mutually exclusive flags: success, or a timeout at one of the three waits. A separate sticky flag records a checksum error.

Top module: `cfg_loader`

## Requirements
- R1: After reset the program line is high, busy is low, no outcome flag or error flag is set, the write strobe and write enable are low, and byte_ready_o is low.
- R2: A start in idle drives the program line low and raises busy on the next clock. If init stays high, the init-low timeout flag is set and the program line released after exactly POLL_LIMIT cycles of busy.
- R3: Once init is seen low, the program line is released. If init is not seen high again within POLL_LIMIT polls, the init-high timeout flag is set and busy drops.
- R4: After init returns high, exactly len_i bytes are accepted, one per valid/ready handshake. Each is presented on cfg_data_o with cfg_wr_o high for one cycle, in arrival order. byte_ready_o is high only in the streaming phase.
- R5: With rev_en_i high at start, each written byte is bit-reversed: input bit k appears on output bit 7-k. With it low, bytes pass unchanged.
- R6: If the synchronised init is low when a byte is accepted, crc_err_o is set. It stays set until the next accepted start, and the remaining bytes are still written.
- R7: After the last byte, done is polled. Seeing it high sets ok_o. Not seeing it within POLL_LIMIT polls sets to_done_o instead. At most one of ok_o and the three timeout flags is ever high.
- R8: status_o carries synchronised done in bit 0, synchronised init in bit 1, the program line level in bit 2 and the write enable in bit 5. All other bits are zero.
- R9: After success, the program line is high and cfg_wen_o is high, and both stay that way until the next start.
- R10: A start request while busy is ignored. The sequence in progress continues and the byte count is unchanged.
- R11: A length of zero skips streaming and goes straight from the init-high wait to the done wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request (taken only when idle) |
| len_i | input | LEN_W | Payload length in bytes, captured at start |
| rev_en_i | input | 1 | Bit-reverse mode, captured at start |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_ready_o | output | 1 | Block accepts a payload byte this cycle |
| prog_n_o | output | 1 | Active-low program line to the device |
| init_i | input | 1 | Device init line (asynchronous) |
| done_i | input | 1 | Device done line (asynchronous) |
| cfg_data_o | output | 8 | Parallel configuration data |
| cfg_wr_o | output | 1 | One-cycle write strobe for cfg_data_o |
| cfg_wen_o | output | 1 | Write enable level toward the device |
| status_o | output | 8 | Line status word |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Configuration finished with done seen |
| to_init_low_o | output | 1 | Init never went low after program |
| to_init_high_o | output | 1 | Init never returned high |
| to_done_o | output | 1 | Done never went high |
| crc_err_o | output | 1 | Init seen low while writing payload (sticky) |

## Verification
The checksum monitor and the end-of-payload transition can act on the same clock edge. This happens when init is already low as the final byte is accepted. The bench provokes it by holding init low across the last two bytes of a payload. It then checks that the error flag is set, that every byte including the last one reached the data port, and that the done wait still runs and reports success. A second collision, a start request arriving mid-stream, is judged by the program line staying high, busy staying high and the final byte count matching the original length.

// File: rtl/cfg_loader_pkg.sv
// Shared definitions for the configuration handshake sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_WAIT_LOW  = 3'd1,
        SEQ_WAIT_HIGH = 3'd2,
        SEQ_STREAM    = 3'd3,
        SEQ_WAIT_DONE = 3'd4
    } seq_state_t;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_INIT_BIT = 1;
    localparam int STAT_PROG_BIT = 2;
    localparam int STAT_WEN_BIT  = 5;
    localparam int STAT_W        = 8;

endpackage

// File: rtl/cfg_sync.sv
// Multi-bit two-or-more stage synchroniser; one independent chain per bit.
// Assumes: each bit is a slow level; no cross-bit coherence is required.
module cfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Shift the raw level through the chain of flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
            assign q_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg_bitrev.sv
// Byte bit-reverser built as per-nibble reversal followed by a nibble swap.
// Assumes: purely combinational; enable picks reversed or pass-through.
module cfg_bitrev #(
    parameter int NIB_W = 4,
    localparam int NIBS = 2,
    localparam int BYTE_W = NIB_W * NIBS
) (
    input  logic              en_i,
    input  logic [BYTE_W-1:0] d_i,
    output logic [BYTE_W-1:0] q_o
);
    logic [BYTE_W-1:0] swapped;

    genvar n, k;
    generate
        for (n = 0; n < NIBS; n++) begin : g_nib
            for (k = 0; k < NIB_W; k++) begin : g_bit
                // Bit k of nibble n lands at bit NIB_W-1-k of the opposite nibble.
                assign swapped[(NIBS-1-n)*NIB_W + (NIB_W-1-k)] = d_i[n*NIB_W + k];
            end
        end
    endgenerate

    assign q_o = en_i ? swapped : d_i;
endmodule

// File: rtl/cfg_poll_timer.sv
// Bounded poll counter: counts polls while running, flags the final one.
// Assumes: clear has priority over run; clear on entry to every wait state.
module cfg_poll_timer #(
    parameter int LIMIT = 10000,
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic last_o
);
    logic [CNT_W-1:0] cnt_q;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT - 1);

    assign last_o = run_i && (cnt_q == CNT_END);

    // Count one poll per cycle, holding at the end value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (run_i && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_END);
endmodule

// File: rtl/cfg_loader.sv
// Configuration handshake sequencer top level.
// Drives program low, waits init low, releases program, waits init high,
// streams len bytes to the data port, then waits for done. Each wait is
// bounded by POLL_LIMIT polls (one per clock).
// Assumes: init_i/done_i are asynchronous levels; byte stream is valid/ready.
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int POLL_LIMIT = 10000,
    parameter int LEN_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             rev_en_i,
    input  logic [7:0]       byte_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             prog_n_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic [7:0]       cfg_data_o,
    output logic             cfg_wr_o,
    output logic             cfg_wen_o,
    output logic [7:0]       status_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic             to_init_low_o,
    output logic             to_init_high_o,
    output logic             to_done_o,
    output logic             crc_err_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] remain_q;
    logic             rev_q;
    logic             init_s, done_s;
    logic             tmr_clr, tmr_run, tmr_last;
    logic             start_acc, take;
    logic [7:0]       byte_out;

    cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({done_i, init_i}),
        .q_o  ({done_s, init_s})
    );

    cfg_bitrev #(.NIB_W(4)) u_rev (
        .en_i(rev_q),
        .d_i (byte_i),
        .q_o (byte_out)
    );

    cfg_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(tmr_clr),
        .run_i  (tmr_run),
        .last_o (tmr_last)
    );

    assign busy_o       = (state_q != SEQ_IDLE);
    assign byte_ready_o = (state_q == SEQ_STREAM);
    assign start_acc    = (state_q == SEQ_IDLE) && start_i;
    assign take         = byte_ready_o && byte_valid_i;
    assign tmr_run      = (state_q == SEQ_WAIT_LOW) || (state_q == SEQ_WAIT_HIGH)
                       || (state_q == SEQ_WAIT_DONE);

    // Next-state selection and poll-timer clear on each wait entry.
    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            SEQ_IDLE: if (start_i) begin
                state_d = SEQ_WAIT_LOW;
                tmr_clr = 1'b1;
            end
            SEQ_WAIT_LOW: begin
                if (!init_s) begin
                    state_d = SEQ_WAIT_HIGH;
                    tmr_clr = 1'b1;
                end else if (tmr_last) begin
                    state_d = SEQ_IDLE;
                end
            end
            SEQ_WAIT_HIGH: begin
                if (init_s) begin
                    state_d = (remain_q == '0) ? SEQ_WAIT_DONE : SEQ_STREAM;
                    tmr_clr = 1'b1;
                end else if (tmr_last) begin
                    state_d = SEQ_IDLE;
                end
            end
            SEQ_STREAM: if (take && remain_q == LEN_ONE) begin
                state_d = SEQ_WAIT_DONE;
                tmr_clr = 1'b1;
            end
            SEQ_WAIT_DONE: if (done_s || tmr_last) state_d = SEQ_IDLE;
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Program line: low from start until init answers or the first wait expires.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_n_o <= 1'b1;
        else if (start_acc) prog_n_o <= 1'b0;
        else if (state_q == SEQ_WAIT_LOW && (!init_s || tmr_last)) prog_n_o <= 1'b1;
    end

    // Write enable: raised when init returns high, kept until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) cfg_wen_o <= 1'b0;
        else if (state_q == SEQ_WAIT_HIGH && init_s) cfg_wen_o <= 1'b1;
    end

    // Capture length and mode at start; count down accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            rev_q    <= 1'b0;
        end else if (start_acc) begin
            remain_q <= len_i;
            rev_q    <= rev_en_i;
        end else if (take) begin
            remain_q <= remain_q - LEN_ONE;
        end
    end

    // Data port: register the (optionally reversed) byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_data_o <= '0;
            cfg_wr_o   <= 1'b0;
        end else begin
            cfg_wr_o <= take;
            if (take) cfg_data_o <= byte_out;
        end
    end

    // Outcome and error flags: cleared on start, set by their events.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            ok_o           <= 1'b0;
            to_init_low_o  <= 1'b0;
            to_init_high_o <= 1'b0;
            to_done_o      <= 1'b0;
            crc_err_o      <= 1'b0;
        end else begin
            if (state_q == SEQ_WAIT_LOW && init_s && tmr_last)   to_init_low_o  <= 1'b1;
            if (state_q == SEQ_WAIT_HIGH && !init_s && tmr_last) to_init_high_o <= 1'b1;
            if (state_q == SEQ_WAIT_DONE && done_s)              ok_o           <= 1'b1;
            if (state_q == SEQ_WAIT_DONE && !done_s && tmr_last) to_done_o      <= 1'b1;
            if (take && !init_s)                                 crc_err_o      <= 1'b1;
        end
    end

    // Status word assembly from synchronised lines and driven levels.
    always_comb begin
        status_o = '0;
        status_o[STAT_DONE_BIT] = done_s;
        status_o[STAT_INIT_BIT] = init_s;
        status_o[STAT_PROG_BIT] = prog_n_o;
        status_o[STAT_WEN_BIT]  = cfg_wen_o;
    end

    // R2
    prog_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    // R4
    wr_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> cfg_wen_o);

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ok_o, to_init_low_o, to_init_high_o, to_done_o}) <= 1);

    // R6
    crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_o && !(start_i && !busy_o)) |=> crc_err_o);

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && byte_ready_o) |=> prog_n_o);
endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
    localparam int LIMIT = 40;
    localparam int LW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic rev_en_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic byte_valid_i = 1'b0;
    logic byte_ready_o, prog_n_o, cfg_wr_o, cfg_wen_o, busy_o;
    logic init_i = 1'b1;
    logic done_i = 1'b0;
    logic [7:0] cfg_data_o, status_o;
    logic ok_o, to_init_low_o, to_init_high_o, to_done_o, crc_err_o;

    int vec_n = 0;
    int err_n = 0;
    int wcnt  = 0;
    logic [7:0] wlog [0:15];
    logic [7:0] pay  [0:7];
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_loader #(.POLL_LIMIT(LIMIT), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .rev_en_i(rev_en_i), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
        .byte_ready_o(byte_ready_o), .prog_n_o(prog_n_o), .init_i(init_i),
        .done_i(done_i), .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o),
        .cfg_wen_o(cfg_wen_o), .status_o(status_o), .busy_o(busy_o),
        .ok_o(ok_o), .to_init_low_o(to_init_low_o),
        .to_init_high_o(to_init_high_o), .to_done_o(to_done_o),
        .crc_err_o(crc_err_o)
    );

    // Write monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (cfg_wr_o) begin
            if (wcnt < 16) wlog[wcnt] = cfg_data_o;
            wcnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            err_n++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    task automatic do_start(input int len, input bit rev);
        @(negedge clk);
        len_i = LW'(len); rev_en_i = rev; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_prog(input logic v);
        int n = 0;
        while (prog_n_o !== v && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic handshake();
        wait_prog(1'b0);
        init_i = 1'b0;
        wait_prog(1'b1);
        init_i = 1'b1;
    endtask

    task automatic feed(input int first, input int last);
        for (int i = first; i <= last; i++) begin
            logic r;
            int n = 0;
            byte_i = pay[i]; byte_valid_i = 1'b1;
            do begin r = byte_ready_o; @(negedge clk); n++; end while (!r && n < 1000);
        end
        byte_valid_i = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 4 * LIMIT + 100) begin @(negedge clk); n++; end
    endtask

    task automatic quiet();
        done_i = 1'b0; init_i = 1'b1; wcnt = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 prog_n", prog_n_o, 1);
        chk("R1 busy", busy_o, 0);
        chk("R1 flags", {ok_o, to_init_low_o, to_init_high_o, to_done_o, crc_err_o}, 0);
        chk("R1 wr/wen/ready", {cfg_wr_o, cfg_wen_o, byte_ready_o}, 0);
        chk("R8 status after reset", status_o, 8'h06);
    endtask

    task automatic t_plain();
        pay[0] = 8'h3C; pay[1] = 8'h81; pay[2] = 8'hF0; pay[3] = 8'h07;
        quiet();
        do_start(4, 0);
        chk("R2 prog low after start", prog_n_o, 0);
        chk("R2 busy after start", busy_o, 1);
        chk("R4 no ready before stream", byte_ready_o, 0);
        handshake();
        feed(0, 3);
        done_i = 1'b1;
        wait_idle();
        chk("R7 ok", ok_o, 1);
        chk("R4 byte count", wcnt, 4);
        for (int i = 0; i < 4; i++) chk("R4 byte order", wlog[i], pay[i]);
        chk("R8 status after success", status_o, 8'h27);
        chk("R9 prog/wen held", {prog_n_o, cfg_wen_o}, 2'b11);
        repeat (5) @(negedge clk);
        chk("R9 prog/wen still held", {prog_n_o, cfg_wen_o}, 2'b11);
        chk("R7 no timeouts", {to_init_low_o, to_init_high_o, to_done_o, crc_err_o}, 0);
    endtask

    task automatic t_rev();
        pay[0] = 8'h01; pay[1] = 8'hA3; pay[2] = 8'h0F; pay[3] = 8'hE2;
        quiet();
        do_start(4, 1);
        handshake();
        feed(0, 3);
        done_i = 1'b1;
        wait_idle();
        chk("R5 count", wcnt, 4);
        chk("R5 rev 01", wlog[0], 8'h80);
        chk("R5 rev A3", wlog[1], 8'hC5);
        chk("R5 rev 0F", wlog[2], 8'hF0);
        chk("R5 rev E2", wlog[3], rev8(8'hE2));
    endtask

    task automatic t_init_low_to();
        int n = 0;
        quiet();
        do_start(2, 0);
        while (busy_o && n < 4 * LIMIT) begin n++; @(negedge clk); end
        chk("R2 busy cycles", n, LIMIT);
        chk("R2 init-low timeout", to_init_low_o, 1);
        chk("R2 other outcomes", {ok_o, to_init_high_o, to_done_o}, 0);
        chk("R2 prog released", prog_n_o, 1);
        chk("R2 no writes", wcnt, 0);
    endtask

    task automatic t_init_high_to();
        quiet();
        do_start(2, 0);
        wait_prog(1'b0);
        init_i = 1'b0;
        wait_idle();
        chk("R3 init-high timeout", to_init_high_o, 1);
        chk("R3 prog released", prog_n_o, 1);
        chk("R3 no ready", byte_ready_o, 0);
        chk("R3 other outcomes", {ok_o, to_init_low_o, to_done_o}, 0);
        init_i = 1'b1;
    endtask

    task automatic t_done_to();
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
        quiet();
        do_start(3, 0);
        handshake();
        feed(0, 2);
        wait_idle();
        chk("R7 done timeout", to_done_o, 1);
        chk("R7 no ok", ok_o, 0);
        chk("R4 bytes before done wait", wcnt, 3);
    endtask

    task automatic t_crc();
        pay[0] = 8'hA0; pay[1] = 8'hA1; pay[2] = 8'hA2; pay[3] = 8'hA3;
        quiet();
        do_start(4, 0);
        handshake();
        feed(0, 1);
        chk("R6 no crc while init high", crc_err_o, 0);
        init_i = 1'b0;
        repeat (3) @(negedge clk);
        feed(2, 3);
        chk("R6 crc raised", crc_err_o, 1);
        init_i = 1'b1;
        done_i = 1'b1;
        wait_idle();
        chk("R6 crc sticky", crc_err_o, 1);
        chk("R6 all bytes written", wcnt, 4);
        chk("R6 last byte", wlog[3], 8'hA3);
        chk("R7 ok with crc", ok_o, 1);
    endtask

    task automatic t_busy_start();
        pay[0] = 8'h5A; pay[1] = 8'h6B; pay[2] = 8'h7C; pay[3] = 8'h8D;
        quiet();
        do_start(4, 0);
        chk("R6 crc cleared by start", crc_err_o, 0);
        handshake();
        feed(0, 1);
        start_i = 1'b1; len_i = LW'(1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 still busy", busy_o, 1);
        chk("R10 prog stays high", prog_n_o, 1);
        chk("R10 still streaming", byte_ready_o, 1);
        feed(2, 3);
        done_i = 1'b1;
        wait_idle();
        chk("R10 count unchanged", wcnt, 4);
        chk("R10 ok", ok_o, 1);
    endtask

    task automatic t_zero();
        quiet();
        do_start(0, 0);
        handshake();
        done_i = 1'b1;
        wait_idle();
        chk("R11 ok", ok_o, 1);
        chk("R11 no writes", wcnt, 0);
        chk("R11 wen raised", cfg_wen_o, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_rev();
        t_init_low_to();
        t_init_high_to();
        t_done_to();
        t_crc();
        t_busy_start();
        t_zero();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vec_n++; err_n++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end
endmodule